// File: doc/BRIEF.md
# Composite Sync Timing Decoder

This block takes the digital composite-sync signal produced by an external sync separator (active low) and, running on the sample clock, measures the width of every low pulse. Too short a pulse is taken as noise and dropped. A pulse of normal width marks a new scan line. A pulse much longer than a line sync marks the start of a new field. From these events the block keeps a line number and a field identifier. It also raises a one-cycle start-of-frame pulse, a per-line visible-picture flag and a sample enable that covers the picture part of each visible line.

All timing comes from the incoming pulses. There is no free-running raster counter. The sample enable starts a fixed back-porch delay after the trailing edge of a line's sync and lasts for the picture duration. A lock tracker suppresses the strobes until two consecutive valid syncs have been seen. It drops lock when the syncs stop for one and a half line periods. A parameter chooses between 625-line/50 Hz timing and 525-line/60 Hz timing. A second parameter gives the sample clock in MHz, and every duration in clocks is derived from these two.

Top module: `vid_sync_decoder`

## Requirements
- R1: After a synchronous reset, line_num is 0, field_id is 1, and sof, active_en, line_vis and lock_lost are all 0.
- R2: A duration of T hundredths of a microsecond is floor(T*CLK_MHZ/100) clocks. With the sync width S = 470 and the noise limit N = 200 in those clocks, a low pulse of w clocks is handled as follows: it is ignored if w < N, it is a line sync if N <= w <= 2*S, and it is a field sync if w > 2*S.
- R3: A line sync adds one to line_num and a field sync clears it to 0. A rejected pulse leaves it unchanged. The new value appears three clock edges after the first edge that samples the sync input high again.
- R4: field_id inverts on every field sync, with 0 meaning the first (odd-line) field. At the same edge as that update, sof is high for exactly one cycle when field_id becomes 0 while locked.
- R5: On a visible line while locked, active_en goes high at the (BP+3)-th edge after the first edge sampling the input high and stays high for exactly PIC cycles. The 625 mode uses BP = 580 and PIC = 5200 in hundredths of a microsecond. On any other line active_en stays low.
- R6: line_vis is high while line_num lies in [VIS_FIRST, VIS_FIRST+VIS_COUNT-1] and the block is locked. The defaults are lines 23 to 310 (625 mode) and lines 20 to 259 (525 mode).
- R7: Lock is gained on the second of two consecutive valid syncs, and that sync's line is already served. While unlocked, active_en, sof and line_vis are held low. Line and field tracking continue.
- R8: When no valid sync arrives for TIMEOUT = floor(3*LINE/2) clocks after the last one, lock is lost and lock_lost rises. The 625 mode uses LINE = 6400 hundredths of a microsecond. lock_lost clears when lock is regained.
- R9: With STD = 1, the 525-line timing applies: LINE = 6356, BP = 470 and PIC = 5266 hundredths of a microsecond, with the same sync and noise widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Composite sync from the separator, low during sync |
| line_num | output | LINE_W | Line number within the current field |
| field_id | output | 1 | 0 = first field, 1 = second field |
| sof | output | 1 | One-cycle start-of-frame pulse |
| active_en | output | 1 | Sample enable over the picture part of a visible line |
| line_vis | output | 1 | Current line carries visible picture |
| lock_lost | output | 1 | Sync was lost and lock has not yet been regained |

## Verification
The hardest state to reach is the recovery from a loss of lock. The bench has to stop the sync train for longer than the timeout, then show that the first valid sync afterwards still yields no window. Only the second sync gives lock back, so it is the first to yield one. The bench reaches this by holding the input idle after a locked run and then sending one line sync and one field sync. It runs with a 1 MHz sample-clock parameter so that a line is 64 clocks. The pulse widths in its vector table sit exactly on the noise limit and on the field threshold. A second instance in 525 mode shares the stimulus so that the shorter back porch is seen on the same lines.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {EV_NONE, EV_LINE, EV_FIELD} sync_ev_t;
  typedef enum logic [1:0] {PH_IDLE, PH_PORCH, PH_PIC} win_ph_t;

  // durations in hundredths of a microsecond
  localparam int SYNC_HUS  = 470;
  localparam int NOISE_HUS = 200;

  function automatic int to_clks(input int hus, input int clk_mhz);
    return (hus * clk_mhz) / 100;
  endfunction

  function automatic int line_hus(input int std);
    return (std != 0) ? 6356 : 6400;
  endfunction

  function automatic int bp_hus(input int std);
    return (std != 0) ? 470 : 580;
  endfunction

  function automatic int pic_hus(input int std);
    return (std != 0) ? 5266 : 5200;
  endfunction

  function automatic int frame_lines(input int std);
    return (std != 0) ? 525 : 625;
  endfunction

  function automatic int vis_first_def(input int std);
    return (std != 0) ? 20 : 23;
  endfunction

  function automatic int vis_count_def(input int std);
    return (std != 0) ? 240 : 288;
  endfunction

endpackage

// File: rtl/vsd_sync_meas.sv
module vsd_sync_meas import vsd_pkg::*; #(
  parameter int NOISE_CLKS = 20,
  parameter int LONG_CLKS  = 94,
  parameter int CNT_W      = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sync_n,
  output sync_ev_t ev
);

  localparam logic [CNT_W-1:0] WID_MAX = '1;

  logic             meta_q, sync_q, prev_q;
  logic [CNT_W-1:0] wid_q;
  logic             rise;

  assign rise = sync_q & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
      wid_q  <= '0;
      ev     <= EV_NONE;
    end else begin
      meta_q <= sync_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
      ev     <= EV_NONE;
      if (!sync_q) begin
        if (wid_q != WID_MAX) wid_q <= wid_q + 1'b1;
      end else begin
        wid_q <= '0;
      end
      if (rise) begin
        if (int'(wid_q) > LONG_CLKS)       ev <= EV_FIELD;
        else if (int'(wid_q) >= NOISE_CLKS) ev <= EV_LINE;
      end
    end
  end

  // a classified pulse yields exactly one event cycle
  assert_ev_single_R2: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_NONE) |=> (ev == EV_NONE));

  // an event only follows a trailing edge of the synchronised input
  assert_ev_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (ev != EV_NONE) |-> $past(rise));

endmodule

// File: rtl/vsd_lock.sv
module vsd_lock #(
  parameter int TIMEOUT = 960,
  parameter int GAP_W   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_valid,
  output logic lock_on,
  output logic locked,
  output logic lost
);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [1:0]       good_q, good_d;
  logic             lost_d;

  always_comb begin
    gap_d   = gap_q;
    good_d  = good_q;
    lock_on = locked;
    lost_d  = lost;
    if (ev_valid) begin
      gap_d = '0;
      if (good_q != 2'd2) good_d = good_q + 2'd1;
      if (good_q != 2'd0) begin
        lock_on = 1'b1;
        lost_d  = 1'b0;
      end
    end else begin
      if (int'(gap_q) < TIMEOUT) gap_d = gap_q + 1'b1;
      if (int'(gap_q) == TIMEOUT - 1) begin
        lock_on = 1'b0;
        good_d  = 2'd0;
        lost_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      good_q <= 2'd0;
      locked <= 1'b0;
      lost   <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      good_q <= good_d;
      locked <= lock_on;
      lost   <= lost_d;
    end
  end

  assert_lost_means_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
    lost |-> !locked);

  // lock can only be gained on a sync event
  assert_lock_on_event_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ev_valid));

endmodule

// File: rtl/vsd_line_ctl.sv
module vsd_line_ctl import vsd_pkg::*; #(
  parameter int LINE_W    = 10,
  parameter int VIS_FIRST = 23,
  parameter int VIS_COUNT = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  sync_ev_t          ev,
  input  logic              lock_on,
  output logic [LINE_W-1:0] line_num,
  output logic              field_id,
  output logic              sof,
  output logic              line_vis
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam int                VIS_LAST = VIS_FIRST + VIS_COUNT - 1;

  logic [LINE_W-1:0] line_d;
  logic              in_win;

  always_comb begin
    line_d = line_num;
    if (ev == EV_FIELD)                          line_d = '0;
    else if (ev == EV_LINE && line_num != LINE_MAX) line_d = line_num + 1'b1;
    in_win = (int'(line_d) >= VIS_FIRST) && (int'(line_d) <= VIS_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_num <= '0;
      field_id <= 1'b1;
      sof      <= 1'b0;
      line_vis <= 1'b0;
    end else begin
      sof <= 1'b0;
      if (ev != EV_NONE) begin
        line_num <= line_d;
        line_vis <= lock_on & in_win;
        if (ev == EV_FIELD) begin
          field_id <= ~field_id;
          sof      <= lock_on & field_id;
        end
      end else if (!lock_on) begin
        line_vis <= 1'b0;
      end
    end
  end

  assert_sof_at_frame_top_R4: assert property (@(posedge clk) disable iff (rst)
    sof |-> (line_num == '0) && !field_id);

  assert_sof_single_R4: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  assert_field_clears_line_R3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_FIELD) |=> (line_num == '0));

endmodule

// File: rtl/vsd_window.sv
module vsd_window import vsd_pkg::*; #(
  parameter int BP_CLKS  = 58,
  parameter int PIC_CLKS = 520,
  parameter int CNT_W    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic lock_on,
  input  logic vis,
  output logic active
);

  localparam logic [CNT_W-1:0] BP_LOAD  = CNT_W'(BP_CLKS - 1);
  localparam logic [CNT_W-1:0] PIC_LOAD = CNT_W'(PIC_CLKS - 1);

  win_ph_t          ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (!lock_on) begin
      ph_q   <= PH_IDLE;
      active <= 1'b0;
    end else if (start) begin
      ph_q   <= PH_PORCH;
      cnt_q  <= BP_LOAD;
      active <= 1'b0;
    end else begin
      case (ph_q)
        PH_PORCH: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_PIC;
            cnt_q  <= PIC_LOAD;
            active <= vis;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PIC: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_IDLE;
            active <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: active <= 1'b0;
      endcase
    end
  end

  assert_active_only_visible_R5: assert property (@(posedge clk) disable iff (rst)
    active |-> vis);

  assert_active_not_in_porch_R5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_PORCH) |-> !active);

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder import vsd_pkg::*; #(
  parameter  int STD       = 0,
  parameter  int CLK_MHZ   = 10,
  parameter  int VIS_FIRST = vis_first_def(STD),
  parameter  int VIS_COUNT = vis_count_def(STD),
  localparam int LINE_W    = $clog2(frame_lines(STD))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csync_n,
  output logic [LINE_W-1:0] line_num,
  output logic              field_id,
  output logic              sof,
  output logic              active_en,
  output logic              line_vis,
  output logic              lock_lost
);

  localparam int LINE_CLKS    = to_clks(line_hus(STD), CLK_MHZ);
  localparam int SYNC_CLKS    = to_clks(SYNC_HUS, CLK_MHZ);
  localparam int NOISE_CLKS   = to_clks(NOISE_HUS, CLK_MHZ);
  localparam int BP_CLKS      = to_clks(bp_hus(STD), CLK_MHZ);
  localparam int PIC_CLKS     = to_clks(pic_hus(STD), CLK_MHZ);
  localparam int LONG_CLKS    = 2 * SYNC_CLKS;
  localparam int TIMEOUT_CLKS = (3 * LINE_CLKS) / 2;
  localparam int WID_W        = $clog2(LONG_CLKS + 2) + 1;
  localparam int GAP_W        = $clog2(TIMEOUT_CLKS + 1);
  localparam int WIN_W        = $clog2(BP_CLKS + PIC_CLKS + 1);

  sync_ev_t ev;
  logic     ev_valid, lock_on, locked;

  assign ev_valid = (ev != EV_NONE);

  vsd_sync_meas #(
    .NOISE_CLKS(NOISE_CLKS), .LONG_CLKS(LONG_CLKS), .CNT_W(WID_W)
  ) meas_i (
    .clk(clk), .rst(rst), .sync_n(csync_n), .ev(ev)
  );

  vsd_lock #(
    .TIMEOUT(TIMEOUT_CLKS), .GAP_W(GAP_W)
  ) lock_i (
    .clk(clk), .rst(rst), .ev_valid(ev_valid),
    .lock_on(lock_on), .locked(locked), .lost(lock_lost)
  );

  vsd_line_ctl #(
    .LINE_W(LINE_W), .VIS_FIRST(VIS_FIRST), .VIS_COUNT(VIS_COUNT)
  ) line_i (
    .clk(clk), .rst(rst), .ev(ev), .lock_on(lock_on),
    .line_num(line_num), .field_id(field_id), .sof(sof), .line_vis(line_vis)
  );

  vsd_window #(
    .BP_CLKS(BP_CLKS), .PIC_CLKS(PIC_CLKS), .CNT_W(WIN_W)
  ) win_i (
    .clk(clk), .rst(rst), .start(ev_valid), .lock_on(lock_on),
    .vis(line_vis), .active(active_en)
  );

  assert_quiet_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (!active_en && !sof && !line_vis));

  assert_lost_drops_window_R8: assert property (@(posedge clk) disable iff (rst)
    lock_lost |-> !active_en);

endmodule

// File: tb/vid_sync_decoder_tb_top.sv
module vid_sync_decoder_tb_top;

  // expected timing from the requirements, with CLK_MHZ = 1
  localparam int MHZ   = 1;
  localparam int BP_A  = (580 * MHZ) / 100;
  localparam int PIC_A = (5200 * MHZ) / 100;
  localparam int BP_B  = (470 * MHZ) / 100;
  localparam int PIC_B = (5266 * MHZ) / 100;
  localparam int TO_A  = (3 * ((6400 * MHZ) / 100)) / 2;
  localparam int TO_B  = (3 * ((6356 * MHZ) / 100)) / 2;

  typedef struct packed {
    logic [7:0] w;
    logic [7:0] hi;
    logic [9:0] line;
    logic       fld;
    logic       vis;
    logic       sof;
  } vec_t;

  // VIS_FIRST = 3, VIS_COUNT = 4: lines 3..6 visible
  localparam vec_t VECS [16] = '{
    '{8'd4,  8'd60, 10'd1, 1'b1, 1'b0, 1'b0},  // line, first good sync, unlocked
    '{8'd20, 8'd44, 10'd0, 1'b0, 1'b0, 1'b1},  // field, locks, frame start
    '{8'd1,  8'd10, 10'd0, 1'b0, 1'b0, 1'b0},  // R2 noise rejected
    '{8'd4,  8'd60, 10'd1, 1'b0, 1'b0, 1'b0},
    '{8'd8,  8'd56, 10'd2, 1'b0, 1'b0, 1'b0},  // R2 2*S is still a line
    '{8'd2,  8'd62, 10'd3, 1'b0, 1'b1, 1'b0},  // R2 noise limit is valid
    '{8'd4,  8'd60, 10'd4, 1'b0, 1'b1, 1'b0},
    '{8'd4,  8'd60, 10'd5, 1'b0, 1'b1, 1'b0},
    '{8'd3,  8'd61, 10'd6, 1'b0, 1'b1, 1'b0},  // last visible line
    '{8'd4,  8'd60, 10'd7, 1'b0, 1'b0, 1'b0},
    '{8'd9,  8'd55, 10'd0, 1'b1, 1'b0, 1'b0},  // R2 just above 2*S: field
    '{8'd4,  8'd60, 10'd1, 1'b1, 1'b0, 1'b0},
    '{8'd4,  8'd60, 10'd2, 1'b1, 1'b0, 1'b0},
    '{8'd4,  8'd60, 10'd3, 1'b1, 1'b1, 1'b0},
    '{8'd27, 8'd37, 10'd0, 1'b0, 1'b0, 1'b1},
    '{8'd4,  8'd60, 10'd1, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic [9:0] line_num, line_num_b;
  logic field_id, sof, act, vis, lost;
  logic field_id_b, sof_b, act_b, vis_b, lost_b;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_sync_decoder #(.STD(0), .CLK_MHZ(MHZ), .VIS_FIRST(3), .VIS_COUNT(4)) dut_i (
    .clk(clk), .rst(rst), .csync_n(csync_n), .line_num(line_num), .field_id(field_id),
    .sof(sof), .active_en(act), .line_vis(vis), .lock_lost(lost)
  );

  vid_sync_decoder #(.STD(1), .CLK_MHZ(MHZ), .VIS_FIRST(3), .VIS_COUNT(4)) dut525_i (
    .clk(clk), .rst(rst), .csync_n(csync_n), .line_num(line_num_b), .field_id(field_id_b),
    .sof(sof_b), .active_en(act_b), .line_vis(vis_b), .lock_lost(lost_b)
  );

  task automatic chk(input string req, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    csync_n = 1'b0;
    repeat (w) @(negedge clk);
    csync_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    int rise_a = 0, n_a = 0, rise_b = 0, n_b = 0, n_sof = 0, sof_at = 0;
    pulse(int'(v.w));
    for (int i = 1; i <= int'(v.hi); i++) begin
      @(negedge clk);
      if (i == 4) begin
        chk("R2/R3 line number", int'(line_num), int'(v.line));
        chk("R4 field id", int'(field_id), int'(v.fld));
        chk("R6 visible flag", int'(vis), int'(v.vis));
      end
      if (sof) begin n_sof++; sof_at = i; end
      if (act) begin if (n_a == 0) rise_a = i; n_a++; end
      if (act_b) begin if (n_b == 0) rise_b = i; n_b++; end
    end
    chk("R4 sof count", n_sof, int'(v.sof));
    if (v.sof) chk("R4 sof cycle", sof_at, 4);
    chk("R5 active length", n_a, v.vis ? PIC_A : 0);
    if (v.vis) chk("R5 active start", rise_a, 4 + BP_A);
    chk("R9 active length 525", n_b, v.vis ? PIC_B : 0);
    if (v.vis) chk("R9 active start 525", rise_b, 4 + BP_B);
  endtask

  task automatic chk_reset;
    chk("R1 line number", int'(line_num), 0);
    chk("R1 field id", int'(field_id), 1);
    chk("R1 strobes", int'({sof, act, vis}), 0);
    chk("R1 lock lost", int'(lost), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_reset();

    foreach (VECS[k]) run_vec(VECS[k]);

    // R8: silence after a line sync, timeout measured from the output update
    pulse(4);
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (i == 3 + TO_A) chk("R8 not yet lost", int'(lost), 0);
      if (i == 4 + TO_A) chk("R8 lock lost", int'(lost), 1);
      if (i == 5 + TO_B) chk("R9 lock lost 525", int'(lost_b), 1);
    end
    chk("R7 quiet when lost", int'({act, vis}), 0);

    // R7: first sync after loss gives no window, second relocks
    run_vec('{8'd4, 8'd60, 10'd3, 1'b0, 1'b0, 1'b0});
    chk("R8 still lost after one sync", int'(lost), 1);
    run_vec('{8'd20, 8'd44, 10'd0, 1'b1, 1'b0, 1'b0});
    chk("R8 lost clears on relock", int'(lost), 0);
    run_vec('{8'd4, 8'd60, 10'd1, 1'b1, 1'b0, 1'b0});
    run_vec('{8'd4, 8'd60, 10'd2, 1'b1, 1'b0, 1'b0});
    run_vec('{8'd4, 8'd60, 10'd3, 1'b1, 1'b1, 1'b0});
    run_vec('{8'd20, 8'd44, 10'd0, 1'b0, 1'b0, 1'b1});

    // R1: reset in the middle of a locked run
    run_vec('{8'd4, 8'd60, 10'd1, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule